// File: doc/BRIEF.md
# Configurable PAL Output Cell

This block models one output cell of a sum-of-products programmable logic device, together with its share of the AND-OR array. Eight product terms each AND a chosen subset of the 40 array input terms. An OR gate combines them into a sum. The sum drives the pad either directly or through a flip-flop, and a polarity bit can invert it on the way out. The cell also decides what enables the pad driver and which signal it returns to the array as feedback.

Four architecture bits set the shape of the cell. Two are global: `g_reg` and `g_simple`. Two are local: `l_ac1` and `l_inv`. Together they make the cell a registered output, a combinational output with a product-term enable, a dedicated output, or a dedicated input. The AND masks and the per-term disable bits are static configuration inputs.

Top module: `pal_out_cell`

## Requirements
- R1: Product term i is logic 1 exactly when every array input selected by bit j of its mask slice `pt_mask[i*40+j]` is 1. A term whose mask selects nothing evaluates to 1.
- R2: Setting `pt_off[i]` forces term i to 0. A disabled term adds nothing to the OR sum and, when term 0 is the enable source, keeps the pad driver off.
- R3: Term 0 is part of the OR sum only in registered cells and in simple mode. In every other configuration it serves only as the output enable.
- R4: Registered cell (`g_reg`=1, `l_ac1`=0): the flip-flop loads the OR sum on every rising clock edge, and `pad_out` equals Q XOR `l_inv`.
- R5: Combinational cell (every other setting): `pad_out` equals the current OR sum XOR `l_inv`, with no clock delay.
- R6: `pad_oe` depends on the mode:
  - registered cell: `pad_oe` is the inverse of the active-low `oe_pin_n`;
  - simple mode (`g_reg`=0, `g_simple`=1): `pad_oe` is forced to 1 when `l_ac1`=0 (dedicated output) and to 0 when `l_ac1`=1 (dedicated input);
  - otherwise: `pad_oe` is product term 0.
- R7: `fb` returns the true register Q in a registered cell. In a simple-mode dedicated output it returns `adj_pad_in`. In every other case it returns the cell's own `pad_in`.
- R8: While `rst_n` is low the register holds 0. A registered cell with `l_inv`=1 then shows `pad_out`=1 and `fb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| arr_in | input | 40 | True/complement array input terms |
| oe_pin_n | input | 1 | Global output-enable pin, active low |
| pad_in | input | 1 | Value read back from this cell's pad |
| adj_pad_in | input | 1 | Value read from the adjacent cell's pad |
| pt_mask | input | 320 | AND masks, 40 bits per product term, term 0 lowest |
| pt_off | input | 8 | Per-term disable bits |
| g_reg | input | 1 | Global: registered family select |
| g_simple | input | 1 | Global: simple mode select (when `g_reg`=0) |
| l_ac1 | input | 1 | Local: cell type select |
| l_inv | input | 1 | Local: output polarity, 1 = inverting |
| pad_out | output | 1 | Value to drive onto the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback term returned to the array |

## Verification
The cell holds only one bit of state, the register. Because of that, a wrong Q appears one clock edge later at `pad_out` and `fb`, but only in registered cells. In every other mode a faulty Q cannot be seen at the ports, so the stimulus switches modes often and keeps registered cells active across consecutive edges. Mistakes in term 0 routing or in enable selection are purely combinational and show on `pad_oe` or `pad_out` in the same cycle. The bench therefore compares every output after each input change against a model that follows the mode encoding.

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
  parameter int N_IN = 40,
  parameter int N_PT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      arr_in,
  input  logic                 oe_pin_n,
  input  logic                 pad_in,
  input  logic                 adj_pad_in,
  input  logic [N_PT*N_IN-1:0] pt_mask,
  input  logic [N_PT-1:0]      pt_off,
  input  logic                 g_reg,
  input  logic                 g_simple,
  input  logic                 l_ac1,
  input  logic                 l_inv,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 fb
);

  logic [N_PT-1:0] pt;
  logic [N_PT-1:0] sum_terms;
  logic            reg_cell, simple, pt0_oe, or_sum, q;

  for (genvar i = 0; i < N_PT; i++) begin : g_pt
    assign pt[i] = ~pt_off[i] & (&(arr_in | ~pt_mask[i*N_IN +: N_IN]));
  end

  assign reg_cell  = g_reg & ~l_ac1;
  assign simple    = ~g_reg & g_simple;
  assign pt0_oe    = ~reg_cell & ~simple;
  assign sum_terms = {pt[N_PT-1:1], pt[0] & ~pt0_oe};
  assign or_sum    = |sum_terms;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= 1'b0;
    else        q <= or_sum;

  assign pad_out = (reg_cell ? q : or_sum) ^ l_inv;
  assign pad_oe  = reg_cell ? ~oe_pin_n : (simple ? ~l_ac1 : pt[0]);
  assign fb      = reg_cell ? q : ((simple & ~l_ac1) ? adj_pad_in : pad_in);

  p_reg_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && reg_cell && $past(reg_cell) && $stable(l_inv)
      |-> pad_out == ($past(or_sum) ^ l_inv));

  p_fb_true_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cell |-> fb == (pad_out ^ l_inv));

  p_dedicated_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    simple && l_ac1 |-> !pad_oe);

  p_dedicated_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    simple && !l_ac1 |-> pad_oe);

  p_off_pt0_no_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pt0_oe && pt_off[0] |-> !pad_oe);

  p_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_cell && (&pt_off) |-> pad_out == l_inv);

endmodule

// File: tb/tb_pal_out_cell.sv
`timescale 1ns/1ps
module tb_pal_out_cell;
  localparam int N_IN = 40;
  localparam int N_PT = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_IN-1:0] arr_in;
  logic oe_pin_n, pad_in, adj_pad_in;
  logic [N_PT*N_IN-1:0] pt_mask;
  logic [N_PT-1:0] pt_off;
  logic g_reg, g_simple, l_ac1, l_inv;
  logic pad_out, pad_oe, fb;

  int errors = 0;
  int checks = 0;
  logic q_m = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  pal_out_cell #(.N_IN(N_IN), .N_PT(N_PT)) dut (
    .clk(clk), .rst_n(rst_n), .arr_in(arr_in), .oe_pin_n(oe_pin_n),
    .pad_in(pad_in), .adj_pad_in(adj_pad_in), .pt_mask(pt_mask),
    .pt_off(pt_off), .g_reg(g_reg), .g_simple(g_simple), .l_ac1(l_ac1),
    .l_inv(l_inv), .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb));

  function automatic logic m_pt(int i);
    if (pt_off[i]) return 1'b0;
    for (int j = 0; j < N_IN; j++)
      if (pt_mask[i*N_IN+j] && !arr_in[j]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic m_regcell();
    return g_reg && !l_ac1;
  endfunction

  function automatic logic m_simple();
    return !g_reg && g_simple;
  endfunction

  function automatic logic m_sum();
    logic s = 1'b0;
    for (int i = 0; i < N_PT; i++) begin
      if (i == 0 && !(m_regcell() || m_simple())) continue;
      s |= m_pt(i);
    end
    return s;
  endfunction

  function automatic logic m_oe();
    if (m_regcell()) return !oe_pin_n;
    if (m_simple()) return !l_ac1;
    return m_pt(0);
  endfunction

  function automatic logic m_pad();
    return (m_regcell() ? q_m : m_sum()) ^ l_inv;
  endfunction

  function automatic logic m_fb();
    if (m_regcell()) return q_m;
    if (m_simple() && !l_ac1) return adj_pad_in;
    return pad_in;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R6 pad_oe", pad_oe, m_oe());
    chk("R7 fb", fb, m_fb());
    if (m_oe()) chk(m_regcell() ? "R4 pad_out" : "R5 pad_out", pad_out, m_pad());
  endtask

  task automatic rand_all();
    for (int i = 0; i < N_PT*N_IN; i++) pt_mask[i] = ($urandom % 14 == 0);
    for (int i = 0; i < N_PT; i++)
      if ($urandom % 5 == 0) pt_mask[i*N_IN +: N_IN] = '0;
    pt_off = N_PT'($urandom) & N_PT'($urandom);
    arr_in = ($urandom % 3 == 0) ? '1 : {$urandom, $urandom};
    oe_pin_n = 1'($urandom); pad_in = 1'($urandom); adj_pad_in = 1'($urandom);
    if ($urandom % 4 == 0) begin
      g_reg = 1'($urandom); g_simple = 1'($urandom);
      l_ac1 = 1'($urandom); l_inv = 1'($urandom);
    end
  endtask

  task automatic step_clock();
    logic nq;
    nq = m_sum();
    @(posedge clk);
    q_m = nq;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    g_reg = 1; g_simple = 0; l_ac1 = 0; l_inv = 1;
    rand_all();
    g_reg = 1; l_ac1 = 0; l_inv = 1; oe_pin_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 pad_out in reset", pad_out, 1'b1);
    chk("R8 fb in reset", fb, 1'b0);
    chk("R6 pin enable", pad_oe, 1'b1);
    rst_n = 1'b1;

    // R1: empty mask true; one selected low input kills the term
    g_reg = 0; g_simple = 1; l_ac1 = 0; l_inv = 0;
    pt_mask = '0; pt_off = 8'hFD; arr_in = '0;
    #1 chk("R1 empty mask", pad_out, 1'b1);
    pt_mask[1*N_IN + 17] = 1'b1;
    #1 chk("R1 selected low", pad_out, 1'b0);
    arr_in[17] = 1'b1;
    #1 chk("R1 selected high", pad_out, 1'b1);

    // R2: disabled terms
    pt_off = 8'hFF;
    #1 chk("R2 all off sum", pad_out, 1'b0);
    g_simple = 0; pt_mask = '0;
    #1 chk("R2 off pt0 no enable", pad_oe, 1'b0);

    // R3: term 0 as enable only vs data
    pt_off = 8'hFE;
    #1 chk("R3 pt0 enables", pad_oe, 1'b1);
    chk("R3 pt0 not in sum", pad_out, 1'b0);
    g_simple = 1;
    #1 chk("R3 pt0 in sum simple", pad_out, 1'b1);
    l_ac1 = 1;
    #1 chk("R6 dedicated input", pad_oe, 1'b0);

    // R4/R7: registered path, inverted polarity
    @(negedge clk);
    g_reg = 1; l_ac1 = 0; l_inv = 1; oe_pin_n = 1;
    pt_off = 8'hFE; pt_mask = '0;
    #1 chk("R6 pin disable", pad_oe, 1'b0);
    step_clock();
    chk("R4 registered 1", pad_out, 1'b0);
    chk("R7 true Q feedback", fb, 1'b1);
    pt_off = 8'hFF;
    #1 chk("R4 no change before edge", pad_out, 1'b0);
    step_clock();
    chk("R4 registered 0", pad_out, 1'b1);

    for (int n = 0; n < 3000; n++) begin
      rand_all();
      #1 chk_all();
      step_clock();
      chk_all();
    end

    done = 1;
    finish_run();
  end
endmodule